// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog counter that runs from a slow tick enable through a selectable prescaler. Software manages it through a small register bus. It writes magic 16-bit values to a key register to start the counter, to refresh it, or to open the configuration registers for writing. The configuration registers are a 3-bit prescaler select, a 12-bit reload value and an optional 12-bit window limit. A status register shows which configuration values are still crossing into the tick domain.

When the count runs out, the block sends a one-clock reset-request pulse to the system reset logic. If the window limit is in use, a refresh that comes too early also sends this pulse. Once started, the counter can be stopped only by the system reset `rst_n`.

Bus decode, by address:

| Address | Register |
|---------|----------|
| 0 | Key |
| 1 | Prescaler select |
| 2 | Reload value |
| 3 | Status |
| 4 | Window limit |

Key codes:

| Code | Action |
|------|--------|
| 0xCCCC | Start |
| 0xAAAA | Refresh |
| 0x5555 | Unlock |

Top module: `kwdt_top`

## Requirements
- R1: After reset, reads return these values: prescaler select 0, reload 0xFFF, window 0xFFF and status 0. The counter is stopped and `wdt_rst_o` is low.
- R2: The key register (address 0) always reads as 0x0000.
- R3: A write to the prescaler (addr 1), reload (addr 2) or window (addr 4) register is ignored unless the last key written was 0x5555. Writing any other key value locks these registers again.
- R4: Writing key 0xCCCC starts the counter and loads it from the reload value. A timeout then comes after (reload+1) × divider ticks. After a timeout, the counter reloads itself and keeps counting.
- R5: The prescaler select p sets the divider: p = 0 to 5 gives 4·2^p, and p = 6 or 7 gives 256.
- R6: Writing key 0xAAAA reloads the counter and clears the prescaler phase, so refreshing on time prevents any timeout.
- R7: An accepted configuration write sets its status flag: bit 0 for the prescaler, bit 1 for the reload value, bit 2 for the window. The flag clears after SYNC_TICKS (default 2) ticks. The new value reads back at once, but the counter uses it only when the flag clears.
- R8: A window limit other than 0xFFF turns the window check on. A 0xAAAA refresh while the running count is above the limit raises a reset request. A refresh at or below the limit does not.
- R9: Before a start, the block never requests a reset. After a start, no key write stops the counter.
- R10: Each reset request is a pulse exactly one clock wide, one clock after the event that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low system reset |
| tick_i | input | 1 | Slow tick enable, one clock wide |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational) |
| wdt_rst_o | output | 1 | Reset-request pulse |

## Verification
The hardest case to reach from the ports is the gap between a configuration value being accepted and being used by the counter. The bench creates this gap on purpose. It unlocks the block, writes a reload value of zero and starts the counter before any tick arrives, so the counter loads the old 0xFFF. It then shows that no timeout occurs once the value has crossed over, until a refresh picks up the zero. The window check is reached the same way: the bench refreshes at once after a start, while the count is still high, and again after a counted number of ticks has brought the count down to the limit exactly.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int KEY_W = 16;

   localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
   localparam logic [KEY_W-1:0] KEY_RELOAD = 16'hAAAA;
   localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;

   typedef enum logic [2:0] {
      RA_KEY  = 3'd0,
      RA_PRE  = 3'd1,
      RA_RLD  = 3'd2,
      RA_STAT = 3'd3,
      RA_WIN  = 3'd4
   } kwdt_addr_e;
endpackage

// File: rtl/kwdt_cfg_sync.sv
module kwdt_cfg_sync #(
   parameter int W = 12,
   parameter int SYNC_TICKS = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] staged_o,
   output logic [W-1:0] active_o,
   output logic         busy_o
);
   localparam int CW = $clog2(SYNC_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_o <= RST_VAL;
         active_o <= RST_VAL;
         busy_o   <= 1'b0;
         cnt_q    <= '0;
      end else if (wr_i) begin
         staged_o <= wdata_i;
         busy_o   <= 1'b1;
         cnt_q    <= '0;
      end else if (busy_o && tick_i) begin
         if (cnt_q == LAST) begin
            active_o <= staged_o;
            busy_o   <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
   parameter int SEL_W = 3,
   parameter int BASE_SHIFT = 2,
   parameter int MAX_SHIFT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             strobe_o
);
   localparam int CNT_W = BASE_SHIFT + MAX_SHIFT;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   int unsigned      sh;

   always_comb begin
      sh    = (int'(sel_i) > MAX_SHIFT) ? MAX_SHIFT : int'(sel_i);
      limit = CNT_W'((32'd1 << (sh + BASE_SHIFT)) - 32'd1);
   end

   assign strobe_o = run_i && tick_i && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr_i)            cnt_q <= '0;
      else if (run_i && tick_i)  cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
   parameter int RLD_W = 12,
   parameter int PRE_W = 3,
   parameter int DATA_W = 16,
   parameter int HAS_WINDOW = 1,
   parameter int SYNC_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_wr_i,
   input  logic [2:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              wdt_rst_o
);
   import kwdt_pkg::*;

   if (DATA_W < KEY_W)   begin : g_bad_data  $error("DATA_W must hold the key");  end
   if (RLD_W > DATA_W)   begin : g_bad_rld   $error("RLD_W exceeds DATA_W");      end
   if (PRE_W != 3)       begin : g_bad_pre   $error("PRE_W must be 3");           end
   if (SYNC_TICKS < 1)   begin : g_bad_sync  $error("SYNC_TICKS must be >= 1");   end

   logic [KEY_W-1:0] key_val;
   logic wr_key, key_start, key_reload, key_refresh;
   logic wr_pre, wr_rld, wr_win;
   logic run_q, unlock_q, rst_q;
   logic [PRE_W-1:0] pre_stage, pre_act;
   logic [RLD_W-1:0] rld_stage, rld_act, win_stage, win_act, cnt_q;
   logic pre_busy, rld_busy, win_busy, win_on, strobe;
   logic fire_zero, fire_win;

   assign key_val     = bus_wdata_i[KEY_W-1:0];
   assign wr_key      = bus_wr_i && (bus_addr_i == RA_KEY);
   assign key_start   = wr_key && (key_val == KEY_START);
   assign key_reload  = wr_key && (key_val == KEY_RELOAD);
   assign key_refresh = key_start || key_reload;
   assign wr_pre      = bus_wr_i && unlock_q && (bus_addr_i == RA_PRE);
   assign wr_rld      = bus_wr_i && unlock_q && (bus_addr_i == RA_RLD);
   assign wr_win      = bus_wr_i && unlock_q && (bus_addr_i == RA_WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         unlock_q <= 1'b0;
      end else begin
         if (key_start) run_q    <= 1'b1;
         if (wr_key)    unlock_q <= (key_val == KEY_UNLOCK);
      end
   end

   kwdt_cfg_sync #(.W(PRE_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_pre),
      .wdata_i(bus_wdata_i[PRE_W-1:0]), .staged_o(pre_stage),
      .active_o(pre_act), .busy_o(pre_busy));

   kwdt_cfg_sync #(.W(RLD_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_rld (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_rld),
      .wdata_i(bus_wdata_i[RLD_W-1:0]), .staged_o(rld_stage),
      .active_o(rld_act), .busy_o(rld_busy));

   if (HAS_WINDOW != 0) begin : g_win
      kwdt_cfg_sync #(.W(RLD_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_win (
         .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_win),
         .wdata_i(bus_wdata_i[RLD_W-1:0]), .staged_o(win_stage),
         .active_o(win_act), .busy_o(win_busy));
      assign win_on = (win_act != '1);
   end else begin : g_nowin
      assign win_stage = '1;
      assign win_act   = '1;
      assign win_busy  = 1'b0;
      assign win_on    = 1'b0;
   end

   kwdt_prescaler #(.SEL_W(PRE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_q),
      .clr_i(key_refresh), .sel_i(pre_act), .strobe_o(strobe));

   assign fire_zero = strobe && (cnt_q == '0) && !key_refresh;
   assign fire_win  = key_reload && run_q && win_on && (cnt_q > win_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
         rst_q <= 1'b0;
      end else begin
         rst_q <= fire_zero || fire_win;
         if (key_refresh)  cnt_q <= rld_act;
         else if (strobe)  cnt_q <= (cnt_q == '0) ? rld_act : cnt_q - 1'b1;
      end
   end

   assign wdt_rst_o = rst_q;

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         RA_PRE:  bus_rdata_o = {{(DATA_W-PRE_W){1'b0}}, pre_stage};
         RA_RLD:  bus_rdata_o = {{(DATA_W-RLD_W){1'b0}}, rld_stage};
         RA_STAT: bus_rdata_o = {{(DATA_W-3){1'b0}}, win_busy, rld_busy, pre_busy};
         RA_WIN:  bus_rdata_o = {{(DATA_W-RLD_W){1'b0}}, win_stage};
         default: bus_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int RLD_W = 12,
   parameter int PRE_W = 3,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_i,
   input logic [2:0]        bus_addr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              wdt_rst_o,
   input logic              run_q,
   input logic              unlock_q,
   input logic [PRE_W-1:0]  pre_stage,
   input logic              rld_busy,
   input logic [RLD_W-1:0]  cnt_q,
   input logic [RLD_W-1:0]  rld_act
);
   import kwdt_pkg::*;

   AST_NEVER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q); // R9
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !wdt_rst_o); // R9
   AST_LOCKED_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == RA_PRE && !unlock_q) |=> $stable(pre_stage)); // R3
   AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == RA_KEY) |-> (bus_rdata_o == '0)); // R2
   AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == RA_RLD && unlock_q) |=> rld_busy); // R7
   AST_REFRESH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == RA_KEY && bus_wdata_i[KEY_W-1:0] == KEY_RELOAD)
      |=> (cnt_q == $past(rld_act))); // R6
endmodule

bind kwdt_top kwdt_chk #(.RLD_W(RLD_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
   .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .wdt_rst_o(wdt_rst_o),
   .run_q(run_q), .unlock_q(unlock_q), .pre_stage(pre_stage),
   .rld_busy(rld_busy), .cnt_q(cnt_q), .rld_act(rld_act));

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
module kwdt_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic [2:0]  bus_addr_i = '0;
   logic [15:0] bus_wdata_i = '0;
   logic [15:0] bus_rdata_o;
   logic        wdt_rst_o;

   int n_checks = 0;
   int n_fail = 0;
   int pulses = 0;
   int run_len = 0;
   int max_run = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   kwdt_top u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o), .wdt_rst_o(wdt_rst_o));

   always @(negedge clk) begin
      if (rst_n && wdt_rst_o) begin
         pulses  = pulses + 1;
         run_len = run_len + 1;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_i = 1'b0; bus_wr_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk);
      bus_addr_i = a;
      #1 v = int'(bus_rdata_o);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
      #1;
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      rd(3'd1, v); check("R1 prescaler", v, 0);
      rd(3'd2, v); check("R1 reload", v, 12'hFFF);
      rd(3'd4, v); check("R1 window", v, 12'hFFF);
      rd(3'd3, v); check("R1 status", v, 0);
      check("R1 no request", int'(wdt_rst_o), 0);
      wr(3'd0, 16'h5555);
      rd(3'd0, v); check("R2 key reads zero", v, 0);
   endtask

   task automatic t_lock();
      int v;
      do_reset();
      wr(3'd2, 16'h0007);
      rd(3'd2, v); check("R3 locked reload", v, 12'hFFF);
      rd(3'd3, v); check("R3 locked status", v, 0);
      wr(3'd0, 16'h5555); wr(3'd0, 16'h1234); wr(3'd1, 16'h0003);
      rd(3'd1, v); check("R3 relocked prescaler", v, 0);
      wr(3'd0, 16'h5555); wr(3'd1, 16'h0003);
      rd(3'd1, v); check("R3 unlocked prescaler", v, 3);
   endtask

   task automatic t_timeout();
      int base;
      do_reset();
      wr(3'd0, 16'h5555); wr(3'd2, 16'd3); ticks(2);
      wr(3'd0, 16'hCCCC);
      base = pulses;
      ticks(15); check("R4 no early timeout", pulses - base, 0);
      ticks(1);  check("R4 timeout at 16 ticks", pulses - base, 1);
      ticks(16); check("R4 counts again", pulses - base, 2);
      check("R10 one clock wide", max_run, 1);
   endtask

   task automatic t_prescale();
      int sels[3] = '{2, 6, 7};
      int divs[3] = '{16, 256, 256};
      for (int k = 0; k < 3; k++) begin
         int base;
         do_reset();
         wr(3'd0, 16'h5555); wr(3'd2, 16'd0); wr(3'd1, 16'(sels[k])); ticks(2);
         wr(3'd0, 16'hCCCC);
         base = pulses;
         ticks(divs[k] - 1); check("R5 before divider end", pulses - base, 0);
         ticks(1);           check("R5 at divider end", pulses - base, 1);
      end
   endtask

   task automatic t_refresh();
      int base;
      do_reset();
      wr(3'd0, 16'h5555); wr(3'd2, 16'd3); ticks(2);
      wr(3'd0, 16'hCCCC);
      base = pulses;
      for (int i = 0; i < 5; i++) begin
         ticks(12); wr(3'd0, 16'hAAAA);
      end
      check("R6 refresh holds off", pulses - base, 0);
      ticks(16); check("R6 timeout after last refresh", pulses - base, 1);
   endtask

   task automatic t_sync();
      int v, base;
      do_reset();
      wr(3'd0, 16'h5555); wr(3'd2, 16'd0); wr(3'd1, 16'd0); wr(3'd4, 16'hFFF);
      rd(3'd3, v); check("R7 all flags set", v, 7);
      rd(3'd2, v); check("R7 staged readback", v, 0);
      wr(3'd0, 16'hCCCC);
      base = pulses;
      ticks(1); rd(3'd3, v); check("R7 still busy", v, 7);
      ticks(1); rd(3'd3, v); check("R7 flags cleared", v, 0);
      ticks(4); check("R7 old reload was used", pulses - base, 0);
      wr(3'd0, 16'hAAAA);
      ticks(4); check("R7 new reload after crossing", pulses - base, 1);
   endtask

   task automatic t_window();
      int v, base;
      do_reset();
      wr(3'd0, 16'h5555); wr(3'd2, 16'd10); wr(3'd4, 16'd5); ticks(2);
      rd(3'd4, v); check("R8 window readback", v, 5);
      base = pulses;
      wr(3'd0, 16'hCCCC);
      wr(3'd0, 16'hAAAA);
      #1 check("R8 early refresh requests", pulses - base, 1);
      ticks(20);
      wr(3'd0, 16'hAAAA);
      #1 check("R8 refresh at limit allowed", pulses - base, 1);
   endtask

   task automatic t_nostop();
      int base;
      do_reset();
      wr(3'd0, 16'h5555); wr(3'd2, 16'd0); ticks(2);
      base = pulses;
      ticks(20); check("R9 idle before start", pulses - base, 0);
      wr(3'd0, 16'hCCCC); wr(3'd0, 16'h0000);
      ticks(4); check("R9 cannot be stopped", pulses - base, 1);
   endtask

   initial begin
      t_reset();
      t_lock();
      t_timeout();
      t_prescale();
      t_refresh();
      t_sync();
      t_window();
      t_nostop();
      check("R10 one clock wide overall", max_run, 1);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule